// File: doc/BRIEF.md
# Receive Status Flags for a Serial Receiver

This block keeps the receive-side status of an asynchronous serial port: receive-data-full, framing error, parity error and a break indication, plus a receiver-active bit and the stored ninth data bit. A receiver core hands it one result per character. That result is a frame-done pulse, a flag saying every data bit (and the parity bit, when one is used) sampled low, the sampled stop bit, a parity-error flag and the ninth data bit. The block also watches the raw receive line through its own synchronizer.

Software sees two status bytes and clears flags with a two-step read. It first reads the status byte that shows the flag while the flag is set, and later reads the data register. A flag raised again between those two reads survives the data read. The break flag has one more rule. Once a break has set it, it cannot set again until the line has been seen high. A break stuck low for many character times therefore reports only once. The parity-error flag can raise an interrupt request when enabled. The break flag never requests anything.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, both status bytes, the stored ninth bit and the interrupt request are 0.
- R2: A frame-done with the parity-error input high sets the parity flag (status 1 bit 0); the interrupt request is high exactly while that flag and the enable are both 1.
- R3: The parity flag clears only when status 1 is read while the flag is 1 and the data register is read in a later cycle; a data read without that arming read leaves it set.
- R4: A break frame (frame-done with all-zero data and stop bit 0) sets, in the same cycle, the break flag (status 2 bit 1), the framing flag (status 1 bit 1) and the data-full flag (status 1 bit 5).
- R5: Every frame-done sets data-full; the framing flag is set when the stop bit is 0; in 9-bit mode the ninth bit input is stored.
- R6: In 9-bit mode a break frame clears the stored ninth bit; frames received outside 9-bit mode leave it unchanged.
- R7: The break flag clears only through a status 2 read while set followed by a data read; that sequence leaves the status 1 flags untouched unless status 1 was also read.
- R8: After a break has set the break flag, further break frames do not set it again until the synchronized line has been high for at least one cycle.
- R9: If a flag is set again between its status read and the data read, the data read leaves it set and a new status read is needed.
- R10: Status 2 bit 0 goes to 1 on a falling edge of the synchronized line and back to 0 on frame-done; status 2 bits 7..2 and status 1 bits 7..6 and 4..2 read 0.
- R11: The break flag never drives the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle pulse per received character |
| frm_zero | input | 1 | All data bits and the parity bit sampled 0 |
| frm_stop | input | 1 | Sampled stop bit value |
| frm_par_err | input | 1 | Parity check failed for this character |
| frm_bit9 | input | 1 | Ninth data bit of this character |
| rxd | input | 1 | Raw receive line level |
| rd_sts1 | input | 1 | Read strobe for status byte 1 |
| rd_sts2 | input | 1 | Read strobe for status byte 2 |
| rd_data | input | 1 | Read strobe for the data register |
| mode9 | input | 1 | 9-bit character mode |
| par_ie | input | 1 | Parity interrupt enable |
| sts1_q | output | 8 | Status byte 1 read value |
| sts2_q | output | 8 | Status byte 2 read value |
| bit9_q | output | 1 | Stored ninth received bit |
| par_irq | output | 1 | Parity error interrupt request |

## Verification
Character results are applied as clean frames, frames with only a parity error, frames with a low stop bit over non-zero data, and all-zero frames with a low stop bit. This separates the framing-only case from a true break. Break frames are repeated with the line held low and then again after the line has gone high, so a flag that re-arms too early shows up. The read strobes are issued alone, in the proper order and with a new error slipped in between. These cases show whether a clear needs both steps and whether a fresh error survives.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  localparam int STS_W  = 8;
  // status byte 1 bit positions
  localparam int S1_PE  = 0;
  localparam int S1_FE  = 1;
  localparam int S1_RDF = 5;
  // status byte 2 bit positions
  localparam int S2_ACT = 0;
  localparam int S2_BRK = 1;
  // internal flag vector indices
  localparam int NFLG   = 3;
  localparam int F_PE   = 0;
  localparam int F_FE   = 1;
  localparam int F_RDF  = 2;

  typedef struct packed {
    logic done;
    logic zero;
    logic stop;
    logic perr;
    logic bit9;
  } frame_t;
endpackage

// File: rtl/rxsf_sync.sv
module rxsf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= {STAGES{RST_VAL}};
    end else begin
      sr[0] <= d;
      for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rxsf_flag.sv
module rxsf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic arm_rd,
  input  logic clr_rd,
  output logic flag
);
  logic armed;

  // priority: new event > completing clear > arming read
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (clr_rd && armed) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (arm_rd && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rxsf_brk_det.sv
module rxsf_brk_det (
  input  logic clk,
  input  logic rst,
  input  logic rxd_s,
  input  logic frm_done,
  input  logic frm_zero,
  input  logic frm_stop,
  output logic brk_evt,
  output logic brk_set,
  output logic rx_act
);
  logic rxd_d;
  logic armed;

  assign brk_evt = frm_done & frm_zero & ~frm_stop;
  assign brk_set = brk_evt & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_d  <= 1'b1;
      armed  <= 1'b1;
      rx_act <= 1'b0;
    end else begin
      rxd_d <= rxd_s;
      if (brk_evt)    armed <= 1'b0;
      else if (rxd_s) armed <= 1'b1;
      if (rxd_d && !rxd_s) rx_act <= 1'b1;
      else if (frm_done)   rx_act <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rxsf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_done,
  input  logic             frm_zero,
  input  logic             frm_stop,
  input  logic             frm_par_err,
  input  logic             frm_bit9,
  input  logic             rxd,
  input  logic             rd_sts1,
  input  logic             rd_sts2,
  input  logic             rd_data,
  input  logic             mode9,
  input  logic             par_ie,
  output logic [STS_W-1:0] sts1_q,
  output logic [STS_W-1:0] sts2_q,
  output logic             bit9_q,
  output logic             par_irq
);
  frame_t          frm;
  logic            rxd_s;
  logic            brk_evt;
  logic            brk_set;
  logic            rx_act;
  logic            brk_flag;
  logic [NFLG-1:0] f_set;
  logic [NFLG-1:0] f_q;

  assign frm = '{done: frm_done, zero: frm_zero, stop: frm_stop,
                 perr: frm_par_err, bit9: frm_bit9};

  rxsf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
  );

  rxsf_brk_det u_brk (
    .clk(clk), .rst(rst), .rxd_s(rxd_s),
    .frm_done(frm.done), .frm_zero(frm.zero), .frm_stop(frm.stop),
    .brk_evt(brk_evt), .brk_set(brk_set), .rx_act(rx_act)
  );

  always_comb begin
    f_set        = '0;
    f_set[F_PE]  = frm.done & frm.perr;
    f_set[F_FE]  = frm.done & ~frm.stop;
    f_set[F_RDF] = frm.done;
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_s1
    rxsf_flag u_flag (
      .clk(clk), .rst(rst), .set(f_set[g]),
      .arm_rd(rd_sts1), .clr_rd(rd_data), .flag(f_q[g])
    );
  end

  rxsf_flag u_brk_flag (
    .clk(clk), .rst(rst), .set(brk_set),
    .arm_rd(rd_sts2), .clr_rd(rd_data), .flag(brk_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)                    bit9_q <= 1'b0;
    else if (frm.done && mode9) bit9_q <= brk_evt ? 1'b0 : frm.bit9;
  end

  always_comb begin
    sts1_q         = '0;
    sts1_q[S1_PE]  = f_q[F_PE];
    sts1_q[S1_FE]  = f_q[F_FE];
    sts1_q[S1_RDF] = f_q[F_RDF];
    sts2_q         = '0;
    sts2_q[S2_ACT] = rx_act;
    sts2_q[S2_BRK] = brk_flag;
  end

  assign par_irq = f_q[F_PE] & par_ie;
endmodule

// File: rtl/rx_status_flags_chk.sv
module rx_status_flags_chk
  import rxsf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             frm_done,
  input logic             frm_zero,
  input logic             frm_stop,
  input logic             frm_par_err,
  input logic             mode9,
  input logic             rd_data,
  input logic [STS_W-1:0] sts1_q,
  input logic [STS_W-1:0] sts2_q,
  input logic             bit9_q,
  input logic             par_irq
);
  AST_PE_SET: assert property (@(posedge clk) disable iff (rst)
    (frm_done && frm_par_err) |=> sts1_q[S1_PE]); // R2

  AST_PE_CLR_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    $fell(sts1_q[S1_PE]) |-> $past(rd_data)); // R3

  AST_BRK_SETS_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sts2_q[S2_BRK]) |-> (sts1_q[S1_FE] && sts1_q[S1_RDF])); // R4

  AST_BIT9_ZERO_ON_BRK: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mode9 && frm_zero && !frm_stop) |=> !bit9_q); // R6

  AST_BRK_CLR_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    $fell(sts2_q[S2_BRK]) |-> $past(rd_data)); // R7

  AST_NO_BRK_IRQ: assert property (@(posedge clk) disable iff (rst)
    !sts1_q[S1_PE] |-> !par_irq); // R11
endmodule

bind rx_status_flags rx_status_flags_chk chk_i (.*);

// File: tb/rx_status_flags_tb_top.sv
module rx_status_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_done = 0, frm_zero = 0, frm_stop = 1, frm_par_err = 0, frm_bit9 = 0;
  logic       rxd = 1'b1;
  logic       rd_sts1 = 0, rd_sts2 = 0, rd_data = 0;
  logic       mode9 = 0, par_ie = 0;
  logic [7:0] sts1_q, sts2_q;
  logic       bit9_q, par_irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  rx_status_flags dut_i (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_zero(frm_zero),
    .frm_stop(frm_stop), .frm_par_err(frm_par_err), .frm_bit9(frm_bit9),
    .rxd(rxd), .rd_sts1(rd_sts1), .rd_sts2(rd_sts2), .rd_data(rd_data),
    .mode9(mode9), .par_ie(par_ie), .sts1_q(sts1_q), .sts2_q(sts2_q),
    .bit9_q(bit9_q), .par_irq(par_irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic z, logic s, logic p, logic b);
    @(negedge clk);
    frm_done = 1; frm_zero = z; frm_stop = s; frm_par_err = p; frm_bit9 = b;
    @(negedge clk);
    frm_done = 0; frm_zero = 0; frm_stop = 1; frm_par_err = 0; frm_bit9 = 0;
  endtask

  task automatic rd(int kind);
    @(negedge clk);
    rd_sts1 = (kind == 1); rd_sts2 = (kind == 2); rd_data = (kind == 3);
    @(negedge clk);
    rd_sts1 = 0; rd_sts2 = 0; rd_data = 0;
  endtask

  task automatic clear_all();
    rd(1); rd(2); rd(3);
  endtask

  task automatic line(logic v);
    rxd = v;
    tick(4);
  endtask

  task automatic t_reset();
    chk("R1 sts1", sts1_q, 8'h00);
    chk("R1 sts2", sts2_q, 8'h00);
    chk("R1 bit9", bit9_q, 0);
    chk("R1 irq", par_irq, 0);
  endtask

  task automatic t_parity();
    par_ie = 0;
    frame(0, 1, 1, 0);
    chk("R2 sts1 after parity frame", sts1_q, 8'h21);
    chk("R2 irq disabled", par_irq, 0);
    par_ie = 1;
    tick(1);
    chk("R2 irq enabled", par_irq, 1);
    rd(3);
    chk("R3 data read alone keeps flags", sts1_q, 8'h21);
    rd(1); rd(3);
    chk("R3 two-step clear", sts1_q, 8'h00);
    chk("R2 irq drops", par_irq, 0);
    par_ie = 0;
  endtask

  task automatic t_framing();
    frame(0, 0, 0, 0);
    chk("R5 stop low sets FE and RDF", sts1_q, 8'h22);
    chk("R5 no break on nonzero data", sts2_q, 8'h00);
    clear_all();
    frame(0, 1, 0, 0);
    chk("R5 clean frame sets RDF only", sts1_q, 8'h20);
    clear_all();
  endtask

  task automatic t_bit9_break();
    mode9 = 1;
    frame(0, 1, 0, 1);
    chk("R5 ninth bit stored", bit9_q, 1);
    mode9 = 0;
    frame(0, 1, 0, 0);
    chk("R6 ninth bit kept outside 9-bit mode", bit9_q, 1);
    clear_all();
    line(0);
    mode9 = 1; par_ie = 1;
    frame(1, 0, 0, 1);
    chk("R4 break flag", sts2_q, 8'h02);
    chk("R4 FE and RDF with break", sts1_q, 8'h22);
    chk("R6 break clears ninth bit", bit9_q, 0);
    chk("R11 break gives no irq", par_irq, 0);
    mode9 = 0; par_ie = 0;
  endtask

  task automatic t_brk_clear();
    rd(3);
    chk("R7 data read alone keeps break", sts2_q, 8'h02);
    rd(2); rd(3);
    chk("R7 break cleared", sts2_q, 8'h00);
    chk("R7 status 1 untouched", sts1_q, 8'h22);
    clear_all();
  endtask

  task automatic t_rearm();
    frame(1, 0, 0, 0);
    chk("R8 no re-set while line low", sts2_q, 8'h00);
    chk("R8 FE and RDF still set", sts1_q, 8'h22);
    clear_all();
    line(1);
    line(0);
    frame(1, 0, 0, 0);
    chk("R8 re-set after line high", sts2_q, 8'h02);
    clear_all();
    chk("R8 cleared", sts2_q, 8'h00);
  endtask

  task automatic t_active();
    line(1);
    chk("R10 idle line", sts2_q, 8'h00);
    line(0);
    chk("R10 active after falling edge", sts2_q, 8'h01);
    frame(0, 1, 0, 0);
    chk("R10 active drops on frame done", sts2_q, 8'h00);
    clear_all();
    line(1);
  endtask

  task automatic t_race();
    frame(0, 1, 1, 0);
    chk("R9 parity set", sts1_q, 8'h21);
    rd(1);
    frame(0, 1, 1, 0);
    rd(3);
    chk("R9 new error survives data read", sts1_q, 8'h21);
    clear_all();
    chk("R9 fresh sequence clears", sts1_q, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_parity();
    t_framing();
    t_bit9_break();
    t_brk_clear();
    t_rearm();
    t_active();
    t_race();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule